// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the register-access front end of an eight-line interrupt controller. A host reaches it over a byte-wide bus with a single address bit. Writes to the even address either start an initialization sequence or issue operation commands: ending service of a line, changing the rotation base, selecting what a read returns, entering poll mode and turning special-mask mode on or off. Writes to the odd address carry the remaining initialization words, or load the mask register once initialization is done.

The block holds the mask, in-service and rotation-base registers, the vector base and the mode flags. An external priority resolver supplies the winning line and whether any request is live. The sequencer uses that result on an acknowledge strobe or on a poll read. It produces the interrupt vector, sets the in-service bit unless auto end-of-interrupt is on, and may rotate priority. The mask, in-service, rotation base, special-mask and special-fully-nested values are output so the resolver can use them.

Top module: `intc_cmd_seq`

## Requirements
- R1: After reset every register is zero, the init step is idle, a read at address 1 returns 0 and a read at address 0 returns the pending input.
- R2: A write to address 0 with bit 4 set clears mask, in-service, rotation base, vector base, poll, read select, special mask and both end-of-interrupt modes. It latches a four-word flag from bit 0 and a single flag from bit 1, and expects the vector-base word next.
- R3: At address 1 the first init word loads the vector base from bits 7:3. The sequence then goes to the mode word if single and four-word, to idle if single only, and to a cascade word otherwise. The cascade word is discarded, followed by the mode word if four-word, else idle. Only an idle-step write loads the mask.
- R4: The mode word sets special-fully-nested from bit 4 and auto end-of-interrupt from bit 1, then returns to idle.
- R5: A write to address 0 with bit 4 clear and bit 3 set is a mode command. Bit 2 enters poll mode. With bit 1 set, bit 0 picks in-service (1) or pending (0) for address-0 reads. With bit 6 set, bit 5 becomes special mask.
- R6: Other address-0 writes use bits 7:5 as a code. Code 1 clears the in-service bit that comes first when counting upward modulo 8 from the rotation base. Code 5 does the same and sets the base to that line + 1. Neither code does anything when no bit is in service.
- R7: Code 3 clears the in-service bit given by bits 2:0. Code 7 also sets the base to that line + 1. Code 6 sets the base to bits 2:0 + 1, modulo 8. Code 2 has no effect. Codes 0 and 4 turn rotate-on-auto-end off and on.
- R8: On an acknowledge strobe, the vector output is the vector base in bits 7:3 and the winning line in bits 2:0. The in-service bit of that line is set. With no live request, bits 2:0 read 7 and no state changes.
- R9: In auto end-of-interrupt mode an acknowledge sets no in-service bit. With rotate-on-auto-end on, the rotation base becomes the acknowledged line + 1.
- R10: In poll mode the next read returns 0x80 ORed with the winning line and acknowledges that line, or returns 0 and changes nothing if no request is live. Poll mode then ends.
- R11: Outside poll mode, an address-1 read returns the mask. An address-0 read returns in-service or pending, as last selected.
- R12: An acknowledge and an end-of-interrupt command in the same cycle both take effect. The command picks its line from the in-service value held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (poll side effect on its clock edge) |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| pend_i | input | 8 | Pending-request register from the request logic |
| req_valid | input | 1 | Resolver has a live winning request |
| req_line | input | 3 | Winning line index from the resolver |
| ack | input | 1 | Single-cycle acknowledge strobe |
| vector_o | output | 8 | Interrupt vector for the current acknowledge |
| imr_o | output | 8 | Mask register |
| isr_o | output | 8 | In-service register |
| rot_base_o | output | 3 | Rotation base (highest-priority line) |
| smask_o | output | 1 | Special-mask mode |
| sfnm_o | output | 1 | Special-fully-nested mode |

## Verification
An acknowledge strobe and an end-of-interrupt write can land in the same cycle. One sets an in-service bit and the other clears one. The bench drives both on one clock edge after a line is already in service. It then expects the old bit cleared and the newly acknowledged bit set, which shows that the command chose its line from the value held before the edge. A sweep over every in-service pattern and every rotation base compares the non-specific and rotating end-of-interrupt results against an upward modulo-8 search computed in the bench.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned NLINES = 8;
  localparam int unsigned LW     = $clog2(NLINES);
  localparam int unsigned DW     = 8;

  typedef enum logic [1:0] {
    STEP_IDLE = 2'd0,
    STEP_BASE = 2'd1,
    STEP_CASC = 2'd2,
    STEP_MODE = 2'd3
  } step_e;

  localparam logic [2:0] OP_RAEOI_OFF = 3'd0;
  localparam logic [2:0] OP_EOI_NS    = 3'd1;
  localparam logic [2:0] OP_EOI_SP    = 3'd3;
  localparam logic [2:0] OP_RAEOI_ON  = 3'd4;
  localparam logic [2:0] OP_EOI_NSROT = 3'd5;
  localparam logic [2:0] OP_SETBASE   = 3'd6;
  localparam logic [2:0] OP_EOI_SPROT = 3'd7;
endpackage

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] base,
  output logic          found,
  output logic [LW-1:0] line
);
  // Search upward from base, wrapping modulo N; the nearest set bit wins.
  always_comb begin
    found = 1'b0;
    line  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec[LW'(base + LW'(k))]) begin
        found = 1'b1;
        line  = LW'(base + LW'(k));
      end
    end
  end
endmodule

// File: rtl/intc_init_fsm.sv
module intc_init_fsm
  import intc_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned LW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             data_wr,
  input  logic [DW-1:0]    wdata,
  output step_e            step,
  output logic [DW-LW-1:0] vbase,
  output logic             sfnm,
  output logic             aeoi,
  output logic             load_mask
);
  step_e            step_q, step_n;
  logic [DW-LW-1:0] vbase_q, vbase_n;
  logic             single_q, single_n, four_q, four_n;
  logic             sfnm_q, sfnm_n, aeoi_q, aeoi_n;

  always_comb begin
    step_n   = step_q;
    vbase_n  = vbase_q;
    single_n = single_q;
    four_n   = four_q;
    sfnm_n   = sfnm_q;
    aeoi_n   = aeoi_q;
    if (start) begin
      step_n   = STEP_BASE;
      vbase_n  = '0;
      sfnm_n   = 1'b0;
      aeoi_n   = 1'b0;
      four_n   = wdata[0];
      single_n = wdata[1];
    end else if (data_wr) begin
      unique case (step_q)
        STEP_BASE: begin
          vbase_n = wdata[DW-1:LW];
          if (single_q) step_n = four_q ? STEP_MODE : STEP_IDLE;
          else          step_n = STEP_CASC;
        end
        STEP_CASC: step_n = four_q ? STEP_MODE : STEP_IDLE;
        STEP_MODE: begin
          sfnm_n = wdata[4];
          aeoi_n = wdata[1];
          step_n = STEP_IDLE;
        end
        default: step_n = STEP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q   <= STEP_IDLE;
      vbase_q  <= '0;
      single_q <= 1'b0;
      four_q   <= 1'b0;
      sfnm_q   <= 1'b0;
      aeoi_q   <= 1'b0;
    end else if (start || data_wr) begin
      step_q   <= step_n;
      vbase_q  <= vbase_n;
      single_q <= single_n;
      four_q   <= four_n;
      sfnm_q   <= sfnm_n;
      aeoi_q   <= aeoi_n;
    end
  end

  assign step      = step_q;
  assign vbase     = vbase_q;
  assign sfnm      = sfnm_q;
  assign aeoi      = aeoi_q;
  assign load_mask = data_wr && !start && (step_q == STEP_IDLE);

  // R3: a single controller never visits the cascade step
  a_r3_single_skips_casc: assert property (@(posedge clk) disable iff (!rst_n)
    single_q |-> (step_q != STEP_CASC));
  // R4: the mode word always returns the sequence to idle
  a_r4_mode_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !start && step_q == STEP_MODE) |=> (step_q == STEP_IDLE));
endmodule

// File: rtl/intc_cmd_seq.sv
module intc_cmd_seq
  import intc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pend_i,
  input  logic          req_valid,
  input  logic [LW-1:0] req_line,
  input  logic          ack,
  output logic [DW-1:0] vector_o,
  output logic [DW-1:0] imr_o,
  output logic [DW-1:0] isr_o,
  output logic [LW-1:0] rot_base_o,
  output logic          smask_o,
  output logic          sfnm_o
);
  localparam logic [LW-1:0] SPURIOUS = LW'(NLINES - 1);

  logic [DW-1:0] imr_q, imr_n, isr_q, isr_n, isr_set, isr_clr;
  logic [LW-1:0] rot_q, rot_n;
  logic          rsel_q, rsel_n, poll_q, poll_n, smask_q, smask_n;
  logic          raeoi_q, raeoi_n;

  // command decode
  logic          icw1, ocw3, ocw2, poll_rd, ack_go;
  logic [2:0]    op;
  logic [LW-1:0] tgt;
  assign icw1    = wr_en && !addr && wdata[4];
  assign ocw3    = wr_en && !addr && !wdata[4] && wdata[3];
  assign ocw2    = wr_en && !addr && !wdata[4] && !wdata[3];
  assign op      = wdata[7:5];
  assign tgt     = wdata[LW-1:0];
  assign poll_rd = rd_en && poll_q;
  assign ack_go  = (ack || poll_rd) && req_valid;

  step_e            step;
  logic [DW-LW-1:0] vbase;
  logic             sfnm, aeoi, load_mask;

  intc_init_fsm #(.DW(DW), .LW(LW)) u_init (
    .clk(clk), .rst_n(rst_n), .start(icw1), .data_wr(wr_en && addr),
    .wdata(wdata), .step(step), .vbase(vbase), .sfnm(sfnm), .aeoi(aeoi),
    .load_mask(load_mask)
  );

  logic          eoi_found;
  logic [LW-1:0] eoi_line;
  intc_pick #(.N(NLINES), .LW(LW)) u_pick (
    .vec(isr_q), .base(rot_q), .found(eoi_found), .line(eoi_line)
  );

  always_comb begin
    isr_set = '0;
    isr_clr = '0;
    rot_n   = rot_q;
    raeoi_n = raeoi_q;
    rsel_n  = rsel_q;
    poll_n  = poll_q;
    smask_n = smask_q;
    imr_n   = imr_q;
    if (poll_rd) poll_n = 1'b0;
    if (ack_go) begin
      if (!aeoi)        isr_set[req_line] = 1'b1;
      else if (raeoi_q) rot_n = LW'(req_line + 1'b1);
    end
    if (ocw2) begin
      unique case (op)
        OP_RAEOI_OFF: raeoi_n = 1'b0;
        OP_RAEOI_ON:  raeoi_n = 1'b1;
        OP_EOI_NS, OP_EOI_NSROT: if (eoi_found) begin
          isr_clr[eoi_line] = 1'b1;
          if (op == OP_EOI_NSROT) rot_n = LW'(eoi_line + 1'b1);
        end
        OP_EOI_SP:    isr_clr[tgt] = 1'b1;
        OP_SETBASE:   rot_n = LW'(tgt + 1'b1);
        OP_EOI_SPROT: begin
          isr_clr[tgt] = 1'b1;
          rot_n        = LW'(tgt + 1'b1);
        end
        default: ;
      endcase
    end
    if (ocw3) begin
      if (wdata[2]) poll_n  = 1'b1;
      if (wdata[1]) rsel_n  = wdata[0];
      if (wdata[6]) smask_n = wdata[5];
    end
    if (load_mask) imr_n = wdata;
    isr_n = (isr_q & ~isr_clr) | isr_set;
    if (icw1) begin
      imr_n = '0; isr_n = '0; rot_n = '0; rsel_n = 1'b0;
      poll_n = 1'b0; smask_n = 1'b0; raeoi_n = 1'b0;
    end
  end

  logic upd;
  assign upd = wr_en || ack_go || poll_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q <= '0; isr_q <= '0; rot_q <= '0; rsel_q <= 1'b0;
      poll_q <= 1'b0; smask_q <= 1'b0; raeoi_q <= 1'b0;
    end else if (upd) begin
      imr_q <= imr_n; isr_q <= isr_n; rot_q <= rot_n; rsel_q <= rsel_n;
      poll_q <= poll_n; smask_q <= smask_n; raeoi_q <= raeoi_n;
    end
  end

  always_comb begin
    if (poll_q)     rdata = req_valid ? {1'b1, {(DW-LW-1){1'b0}}, req_line} : '0;
    else if (addr)  rdata = imr_q;
    else if (rsel_q) rdata = isr_q;
    else            rdata = pend_i;
  end

  assign vector_o   = {vbase, req_valid ? req_line : SPURIOUS};
  assign imr_o      = imr_q;
  assign isr_o      = isr_q;
  assign rot_base_o = rot_q;
  assign smask_o    = smask_q;
  assign sfnm_o     = sfnm;

  // R2: initialization leaves the operating registers cleared
  a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    icw1 |=> (imr_q == '0 && isr_q == '0 && rot_q == '0 && !poll_q));
  // R3: an idle-step write at address 1 lands in the mask
  a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && step == STEP_IDLE) |=> (imr_q == $past(wdata)));
  // R6: a non-specific end clears exactly one bit when any is in service
  a_r6_eoi_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ocw2 && op == OP_EOI_NS && isr_q != '0 && !ack && !rd_en)
    |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
  // R8: a spurious acknowledge changes nothing
  a_r8_spurious_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !req_valid && !wr_en && !rd_en) |=> ($stable(isr_q) && $stable(rot_q)));
  // R9: auto end-of-interrupt acknowledges leave in-service untouched
  a_r9_aeoi_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && aeoi && !wr_en && !rd_en) |=> $stable(isr_q));
  // R10: poll mode ends after one read
  a_r10_poll_once: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll_q && !wr_en) |=> !poll_q);
endmodule

// File: tb/sim_intc_cmd_seq.sv
`timescale 1ns/1ps
module sim_intc_cmd_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0, pend_i = 8'h5A;
  logic       req_valid = 1'b0;
  logic [2:0] req_line = '0;
  logic [7:0] rdata, vector_o, imr_o, isr_o;
  logic [2:0] rot_base_o;
  logic       smask_o, sfnm_o;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;
  logic [7:0] rv, vv;

  always #2.5 clk = ~clk;

  intc_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pend_i(pend_i), .req_valid(req_valid),
    .req_line(req_line), .ack(ack), .vector_o(vector_o), .imr_o(imr_o),
    .isr_o(isr_o), .rot_base_o(rot_base_o), .smask_o(smask_o), .sfnm_o(sfnm_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // one bus cycle; read and vector values sampled before the edge
  task automatic bus(input logic w, input logic r, input logic k, input logic a,
                     input logic [7:0] d, output logic [7:0] rdv, output logic [7:0] vec);
    @(negedge clk);
    wr_en = w; rd_en = r; ack = k; addr = a; wdata = d;
    #1;
    rdv = rdata; vec = vector_o;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; ack = 1'b0;
    #1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    logic [7:0] x, y;
    bus(1'b1, 1'b0, 1'b0, a, d, x, y);
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    logic [7:0] y;
    bus(1'b0, 1'b1, 1'b0, a, 8'h00, v, y);
  endtask

  task automatic do_ack(input logic valid, input logic [2:0] ln, output logic [7:0] vec);
    logic [7:0] x;
    req_valid = valid; req_line = ln;
    bus(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, x, vec);
  endtask

  task automatic fresh_init;
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h00);
  endtask

  function automatic int urgent(input logic [7:0] pat, input int base);
    for (int k = 0; k < 8; k++)
      if (pat[(base + k) % 8]) return (base + k) % 8;
    return -1;
  endfunction

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 imr", imr_o, 0); chk("R1 isr", isr_o, 0); chk("R1 rot", rot_base_o, 0);
    rd(1'b1, rv); chk("R1 read mask", rv, 0);
    rd(1'b0, rv); chk("R1 read pending", rv, 8'h5A);

    // R3/R4: single + four-word sequence
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h48);
    wr(1'b1, 8'h12);
    chk("R4 sfnm", sfnm_o, 1);
    chk("R3 no mask during init", imr_o, 0);
    wr(1'b1, 8'hFF);
    chk("R3 mask after init", imr_o, 8'hFF);
    // R8/R9 auto-EOI acknowledge
    do_ack(1'b1, 3'd2, vv);
    chk("R8 vector", vv, 8'h4A);
    chk("R9 no isr in aeoi", isr_o, 0);
    wr(1'b0, 8'h80);
    do_ack(1'b1, 3'd5, vv);
    chk("R9 rotate on aeoi", rot_base_o, 6);
    wr(1'b0, 8'h00);
    do_ack(1'b1, 3'd1, vv);
    chk("R7 rotate-aeoi off", rot_base_o, 6);

    // R2/R3: cascade, no four-word
    wr(1'b0, 8'h10);
    chk("R2 imr cleared", imr_o, 0); chk("R2 rot cleared", rot_base_o, 0);
    chk("R2 sfnm cleared", sfnm_o, 0);
    wr(1'b1, 8'h20);
    wr(1'b1, 8'h55);
    chk("R3 cascade word discarded", imr_o, 0);
    wr(1'b1, 8'h33);
    chk("R3 mask after cascade", imr_o, 8'h33);

    // R3/R8: cascade + four-word
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h08);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h10);
    wr(1'b1, 8'h0F);
    chk("R3 four-word mask", imr_o, 8'h0F);
    chk("R4 sfnm set", sfnm_o, 1);
    do_ack(1'b1, 3'd3, vv);
    chk("R8 vector base+line", vv, 8'h0B);
    chk("R8 isr set", isr_o, 8'h08);
    do_ack(1'b0, 3'd1, vv);
    chk("R8 spurious vector", vv, 8'h0F);
    chk("R8 spurious no change", isr_o, 8'h08);

    // R3: single only
    wr(1'b0, 8'h12);
    wr(1'b1, 8'hF8);
    wr(1'b1, 8'hA5);
    chk("R3 single-only mask", imr_o, 8'hA5);

    // R7 / R6 directed
    fresh_init;
    do_ack(1'b1, 3'd2, vv); do_ack(1'b1, 3'd4, vv); do_ack(1'b1, 3'd6, vv);
    chk("R8 isr three", isr_o, 8'h54);
    wr(1'b0, 8'h64);
    chk("R7 code3", isr_o, 8'h44);
    wr(1'b0, 8'hE6);
    chk("R7 code7 isr", isr_o, 8'h04); chk("R7 code7 rot", rot_base_o, 7);
    wr(1'b0, 8'hC2);
    chk("R7 code6", rot_base_o, 3);
    wr(1'b0, 8'h40);
    chk("R7 code2 isr", isr_o, 8'h04); chk("R7 code2 rot", rot_base_o, 3);
    do_ack(1'b1, 3'd1, vv); do_ack(1'b1, 3'd5, vv);
    wr(1'b0, 8'hA0);
    chk("R6 code5 isr", isr_o, 8'h06); chk("R6 code5 rot", rot_base_o, 6);
    wr(1'b0, 8'hA0);
    chk("R6 code5 wrap isr", isr_o, 8'h04); chk("R6 code5 wrap rot", rot_base_o, 2);
    wr(1'b0, 8'hC7);
    chk("R7 code6 modulo", rot_base_o, 0);
    // R5 / R11 read select and special mask
    wr(1'b0, 8'h0B);
    rd(1'b0, rv); chk("R11 read isr", rv, 8'h04);
    wr(1'b0, 8'h09);
    rd(1'b0, rv); chk("R5 select unchanged w/o bit1", rv, 8'h04);
    wr(1'b0, 8'h0A);
    rd(1'b0, rv); chk("R11 read pending", rv, 8'h5A);
    wr(1'b0, 8'h68); chk("R5 smask on", smask_o, 1);
    wr(1'b0, 8'h28); chk("R5 smask kept w/o bit6", smask_o, 1);
    wr(1'b0, 8'h48); chk("R5 smask off", smask_o, 0);
    wr(1'b0, 8'hE7);
    chk("R7 code7 line7 rot", rot_base_o, 0);
    wr(1'b0, 8'h20);
    chk("R6 code1", isr_o, 8'h00);
    wr(1'b0, 8'h20);
    chk("R6 code1 empty", isr_o, 8'h00); chk("R6 code1 empty rot", rot_base_o, 0);

    // R10 poll
    fresh_init;
    req_valid = 1'b1; req_line = 3'd3;
    wr(1'b0, 8'h0C);
    rd(1'b0, rv);
    chk("R10 poll value", rv, 8'h83);
    chk("R10 poll acks", isr_o, 8'h08);
    rd(1'b0, rv);
    chk("R10 poll cleared", rv, 8'h5A);
    req_valid = 1'b0;
    wr(1'b0, 8'h0C);
    rd(1'b0, rv);
    chk("R10 poll empty", rv, 8'h00);
    chk("R10 poll empty no ack", isr_o, 8'h08);

    // R12 acknowledge and end-of-interrupt in one cycle
    req_valid = 1'b1; req_line = 3'd5;
    bus(1'b1, 1'b0, 1'b1, 1'b0, 8'h20, rv, vv);
    chk("R12 merged ack+eoi", isr_o, 8'h20);

    // R6 sweep: every pattern, every base, codes 1 and 5
    fresh_init;
    for (int base = 0; base < 8; base++) begin
      for (int pat = 0; pat < 256; pat++) begin
        logic [7:0] p;
        logic [7:0] expv;
        int u, expr;
        bit rotc;
        p = pat[7:0];
        rotc = (pat[0] ^ base[0]);
        wr(1'b0, 8'hC0 | 8'((base + 7) % 8));
        for (int l = 0; l < 8; l++)
          if (p[l]) do_ack(1'b1, 3'(l), vv);
        wr(1'b0, rotc ? 8'hA0 : 8'h20);
        u = urgent(p, base);
        expv = p; expr = base;
        if (u >= 0) begin
          expv[u] = 1'b0;
          if (rotc) expr = (u + 1) % 8;
        end
        chk("R6 sweep isr", isr_o, expv);
        chk("R6 sweep rot", rot_base_o, expr);
        for (int l = 0; l < 8; l++)
          if (expv[l]) wr(1'b0, 8'h60 | 8'(l));
      end
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule